// File: doc/BRIEF.md
# Register File Readback Checker

This block sits next to a register file of 32 words by 32 bits and watches its write and read ports. Each write is copied into a shadow array, and a per-address flag records that the address has been written since reset. When a read hits a written address, the data the register file returns is compared with the last value written to that address. A mismatch raises a one-cycle error pulse. The pulse comes with the address, the expected word and the returned word.

A later write to an address replaces the expected value. An older write to the same address then has nothing left to prove. Writes to other addresses do not disturb the check.

The `RD_LAT` parameter sets when read data arrives:
- With `RD_LAT` = 0, read data is valid in the read cycle itself.
- With `RD_LAT` = 1, read data is valid one cycle later. The checker captures the address and the expected word in the read cycle and compares them with the returned data in the next cycle.

Top module: `rf_readback_chk`

## Requirements
- R1: A read of a written address whose returned data equals the last value written there leaves `err_o` low.
- R2: A read of a written address that returns different data drives `err_o` high for exactly one cycle. For `RD_LAT`=0 the pulse is in the cycle after the read cycle. For `RD_LAT`=1 it is two cycles after the read cycle, which is the cycle after the data returns.
- R3: While `err_o` is high, `err_addr_o` holds the read address, `err_exp_o` the last written value and `err_act_o` the returned data.
- R4: A later write to an address replaces its expected value. Returning the newer value raises no error, and returning the older value is flagged.
- R5: Writes to other addresses between a write and a read of address A do not change the check of A.
- R6: A read in the cycle right after a write to the same address is checked against that write.
- R7: Reads of addresses not written since reset never raise `err_o`, whatever data is returned.
- R8: When a read and a write hit the same address in one cycle, the read is checked against the value stored before that write. An address first written in that same cycle is not checked.
- R9: Every mismatching read is reported, including back-to-back reads. N consecutive bad reads give N consecutive error cycles.
- R10: Reset clears all written flags and drives `err_o`, `err_addr_o`, `err_exp_o` and `err_act_o` to zero.
- R11: With `RD_LAT`=1, the expected value is taken in the read cycle. A write to the same address in the cycle the data returns does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register file write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Register file read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid RD_LAT cycles after the read strobe |
| err_o | output | 1 | One-cycle mismatch pulse |
| err_addr_o | output | ADDR_W | Address of the failing read |
| err_exp_o | output | DATA_W | Expected data of the failing read |
| err_act_o | output | DATA_W | Returned data of the failing read |

## Verification
The error outputs are registered, so a verdict appears one clock after the data it judges is valid. That is one cycle after the read strobe with same-cycle data, and two cycles after it with registered data. The bench drives the same stimulus into one instance of each latency and computes each read's verdict at the read cycle from its own model. It then checks the same-cycle instance after the next edge and the registered instance one step later, holding that verdict in a pending slot. Every read is followed by a sample at the negative edge, so back-to-back pulses are each seen in their own cycle.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum int unsigned {
    RD_SAME = 0,
    RD_NEXT = 1
  } rd_lat_e;
endpackage

// File: rtl/rfc_shadow.sv
module rfc_shadow #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  seen_q;

  // data array carries no reset; only the flags gate the check
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          seen_q[g] <= 1'b0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(g)))        seen_q[g] <= 1'b1;
    end
  end

  // lookup sees pre-write state when read and write collide
  assign lk_hit_o  = seen_q[lk_addr_i];
  assign lk_data_o = mem_q[lk_addr_i];
endmodule

// File: rtl/rfc_align.sv
module rfc_align #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RD_LAT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic              chk_vld_o,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic [DATA_W-1:0] chk_exp_o
);
  if (RD_LAT == rfc_pkg::RD_SAME) begin : g_same
    assign chk_vld_o  = rd_en_i && hit_i;
    assign chk_addr_o = rd_addr_i;
    assign chk_exp_o  = exp_i;
  end else begin : g_next
    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= 1'b0;
      else         vld_q <= rd_en_i && hit_i;
    end

    always_ff @(posedge clk_i) begin
      if (rd_en_i) begin
        addr_q <= rd_addr_i;
        exp_q  <= exp_i;
      end
    end

    assign chk_vld_o  = vld_q;
    assign chk_addr_o = addr_q;
    assign chk_exp_o  = exp_q;
  end
endmodule

// File: rtl/rfc_report.sv
module rfc_report #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_vld_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [DATA_W-1:0] chk_exp_i,
  input  logic [DATA_W-1:0] act_i,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_act_o
);
  logic miss;
  assign miss = chk_vld_i && (chk_exp_i != act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_act_o  <= '0;
    end else begin
      err_o <= miss;
      if (miss) begin
        err_addr_o <= chk_addr_i;
        err_exp_o  <= chk_exp_i;
        err_act_o  <= act_i;
      end
    end
  end
endmodule

// File: rtl/rf_readback_chk.sv
module rf_readback_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RD_LAT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_act_o
);
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              chk_vld;
  logic [ADDR_W-1:0] chk_addr;
  logic [DATA_W-1:0] chk_exp;

  rfc_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lk_addr_i (rd_addr_i),
    .lk_hit_o  (lk_hit),
    .lk_data_o (lk_data)
  );

  rfc_align #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .hit_i      (lk_hit),
    .exp_i      (lk_data),
    .chk_vld_o  (chk_vld),
    .chk_addr_o (chk_addr),
    .chk_exp_o  (chk_exp)
  );

  rfc_report #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_report (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chk_vld_i  (chk_vld),
    .chk_addr_i (chk_addr),
    .chk_exp_i  (chk_exp),
    .act_i      (rd_data_i),
    .err_o      (err_o),
    .err_addr_o (err_addr_o),
    .err_exp_o  (err_exp_o),
    .err_act_o  (err_act_o)
  );
endmodule

// File: rtl/rf_readback_chk_sva.sv
module rf_readback_chk_sva #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RD_LAT = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              err_o,
  input logic [ADDR_W-1:0] err_addr_o,
  input logic [DATA_W-1:0] err_exp_o,
  input logic [DATA_W-1:0] err_act_o
);
  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!err_o && err_addr_o == '0 && err_exp_o == '0 && err_act_o == '0);
    end
  end

  // R3
  err_differs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_exp_o != err_act_o));

  // R3
  err_act_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_act_o == $past(rd_data_i)));

  if (RD_LAT == 0) begin : g_l0
    // R2
    err_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> $past(rd_en_i));
    // R3
    err_addr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (err_addr_o == $past(rd_addr_i)));
  end else begin : g_l1
    // R2
    err_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> $past(rd_en_i, 2));
    // R3
    err_addr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (err_addr_o == $past(rd_addr_i, 2)));
  end
endmodule

bind rf_readback_chk rf_readback_chk_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_i  (rd_data_i),
  .err_o      (err_o),
  .err_addr_o (err_addr_o),
  .err_exp_o  (err_exp_o),
  .err_act_o  (err_act_o)
);

// File: tb/sim_rf_readback_chk.sv
module sim_rf_readback_chk;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0, rd0 = '0, rd1 = '0;

  logic          e0, e1;
  logic [AW-1:0] a0, a1;
  logic [DW-1:0] x0, x1, y0, y1;

  int total = 0, bad = 0;
  bit done = 0;

  bit          m_wr [DEPTH];
  logic [DW-1:0] m_val [DEPTH];

  bit          p_err = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_exp = '0, p_act = '0;
  string       p_tag = "R1";

  always #(CLK_P/2) clk = ~clk;
  always_ff @(posedge clk) rd1 <= rd0;

  rf_readback_chk #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_i(rd0),
    .err_o(e0), .err_addr_o(a0), .err_exp_o(x0), .err_act_o(y0));

  rf_readback_chk #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_i(rd1),
    .err_o(e1), .err_addr_o(a1), .err_exp_o(x1), .err_act_o(y1));

  function automatic logic [DW-1:0] fval(int a, int salt);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 * salt);
  endfunction

  task automatic chk(string tag, string who, bit ge, logic [AW-1:0] ga,
                     logic [DW-1:0] gx, logic [DW-1:0] gy, bit ee,
                     logic [AW-1:0] ea, logic [DW-1:0] ex, logic [DW-1:0] ey);
    total++;
    if (ge !== ee) begin
      bad++;
      $display("FAIL %s %s err: got %0b exp %0b", tag, who, ge, ee);
    end else if (ee && (ga !== ea || gx !== ex || gy !== ey)) begin
      bad++;
      $display("FAIL %s %s fields: got a=%0d e=%h d=%h exp a=%0d e=%h d=%h",
               tag, who, ga, gx, gy, ea, ex, ey);
    end
  endtask

  // one cycle: drive after negedge, sample at next negedge
  task automatic step(string tag, bit w, int wadr, logic [DW-1:0] wdat,
                      bit r, int radr, logic [DW-1:0] rdat);
    bit n_err;
    logic [DW-1:0] n_exp;
    we = w; wa = AW'(wadr); wd = wdat;
    re = r; ra = AW'(radr); rd0 = rdat;
    n_err = r && m_wr[radr] && (m_val[radr] != rdat);
    n_exp = m_val[radr];
    if (w) begin
      m_wr[wadr] = 1;
      m_val[wadr] = wdat;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "lat0", e0, a0, x0, y0, n_err, AW'(radr), n_exp, rdat);
    chk(p_tag, "lat1", e1, a1, x1, y1, p_err, p_addr, p_exp, p_act);
    p_err = n_err; p_addr = AW'(radr); p_exp = n_exp; p_act = rdat; p_tag = tag;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    we = 0; re = 0;
    for (int i = 0; i < DEPTH; i++) m_wr[i] = 0;
    p_err = 0;
    @(negedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "lat0", e0, a0, x0, y0, 0, '0, '0, '0);
    chk("R10", "lat1", e1, a1, x1, y1, 0, '0, '0, '0);
    total += 2;
    if (a0 !== '0 || x0 !== '0 || y0 !== '0) begin bad++; $display("FAIL R10 lat0 fields not zero: a=%0d e=%h d=%h exp 0", a0, x0, y0); end
    if (a1 !== '0 || x1 !== '0 || y1 !== '0) begin bad++; $display("FAIL R10 lat1 fields not zero: a=%0d e=%h d=%h exp 0", a1, x1, y1); end
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_wr[i] = 0; m_val[i] = '0; end
    @(negedge clk);
    do_reset();

    // R7: unwritten reads, arbitrary data
    for (int a = 0; a < DEPTH; a++) step("R7", 0, 0, '0, 1, a, fval(a, 9));
    idle("R7");

    for (int a = 0; a < DEPTH; a++) step("R1", 1, a, fval(a, 1), 0, 0, '0);
    // R1: all correct
    for (int a = 0; a < DEPTH; a++) step("R1", 0, 0, '0, 1, a, fval(a, 1));
    // R9 / R2 / R3: back-to-back single-bit corruptions
    for (int a = 0; a < DEPTH; a++) step("R9", 0, 0, '0, 1, a, fval(a, 1) ^ (32'h1 << a));
    idle("R2");
    idle("R2");

    // R4: overwrite retargets expected value
    step("R4", 1, 3, fval(3, 2), 0, 0, '0);
    step("R4", 0, 0, '0, 1, 3, fval(3, 2));
    step("R4", 0, 0, '0, 1, 3, fval(3, 1));
    idle("R4");

    // R5: other-address writes between
    step("R5", 1, 7, fval(7, 3), 0, 0, '0);
    step("R5", 1, 8, fval(8, 3), 0, 0, '0);
    step("R5", 1, 6, fval(6, 3), 0, 0, '0);
    step("R5", 0, 0, '0, 1, 7, fval(7, 3));
    step("R5", 0, 0, '0, 1, 7, fval(8, 3));

    // R6: read directly after write
    step("R6", 1, 9, fval(9, 4), 0, 0, '0);
    step("R6", 0, 0, '0, 1, 9, fval(9, 5));
    step("R6", 1, 9, fval(9, 6), 0, 0, '0);
    step("R6", 0, 0, '0, 1, 9, fval(9, 6));

    // R8: same-cycle read+write
    step("R8", 1, 10, fval(10, 7), 1, 10, fval(10, 1));
    step("R8", 1, 10, fval(10, 8), 1, 10, fval(10, 8));
    step("R8", 0, 0, '0, 1, 10, fval(10, 8));
    // R11: write lands while registered data returns
    step("R11", 0, 0, '0, 1, 12, fval(12, 1) ^ 32'h8000_0000);
    step("R11", 1, 12, fval(12, 1) ^ 32'h8000_0000, 0, 0, '0);
    step("R11", 0, 0, '0, 1, 12, fval(12, 1) ^ 32'h8000_0000);
    idle("R11");
    idle("R11");

    // R10: reset forgets flags
    do_reset();
    for (int a = 0; a < 4; a++) step("R10", 0, 0, '0, 1, a, ~fval(a, 1));
    step("R10", 1, 2, fval(2, 11), 0, 0, '0);
    step("R10", 0, 0, '0, 1, 2, fval(2, 12));
    idle("R10");
    idle("R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule